// File: doc/BRIEF.md
# Work-Group Dispatcher

The dispatcher takes launch requests for work groups and places each group, whole, onto one compute cluster. A request states how many hardware threads the group needs, whether it needs a barrier slot, and how many bytes of shared local memory it uses. For each cluster the block keeps a count of free thread slots, free barrier slots and free shared-memory bytes. A group is granted only to a cluster that can cover all three needs at once. When several clusters qualify, the lowest-numbered one wins. A grant deducts the group's needs from that cluster, and a completion message adds them back.

Requests are served strictly in arrival order through one head slot. When no cluster can take the head group, it waits, and every request behind it waits too. A group that would not fit even in an empty cluster cannot ever be placed. It is answered at once with an error grant instead of waiting. In the default build there are four clusters, arranged as two slices of two. Each cluster has 70 thread slots (10 execution units of 7 threads each), 16 barrier slots and 65536 bytes of shared memory.

Top module: `wg_dispatch`

## Requirements
- R1: After reset, grant_valid is 0, req_ready is 1, and every cluster is fully free, so the first group that fits is granted to cluster 0.
- R2: A group is granted to the lowest-indexed cluster that has enough free thread slots and enough free shared-memory bytes, plus a free barrier slot when req_barrier is 1. grant_valid rises one cycle after the clock edge that accepts the request, provided the grant output is free.
- R3: A grant deducts the group's threads, one barrier slot (only when a barrier is needed) and its shared-memory bytes from the chosen cluster. Per cluster the capacities are 70 thread slots, 16 barrier slots and 65536 bytes.
- R4: A group is never split. When no single cluster can cover it, no grant is issued, and the group stays at the head until a completion frees enough room.
- R5: A request with more than 70 threads or more than 65536 bytes is granted with grant_error = 1 and grant_cluster = 0 one cycle after acceptance, and it deducts nothing.
- R6: A completion (done_valid = 1) returns its threads, its barrier slot when done_barrier = 1, and its bytes to cluster done_cluster at the edge that samples it. A waiting head group that now fits is granted one cycle after that edge.
- R7: req_ready is 0 while a request occupies the head slot, so later requests are not accepted until the head group has been granted.
- R8: While grant_valid = 1 and grant_ready = 0, grant_valid, grant_cluster and grant_error hold their values.
- R9: Barrier slots are counted separately from threads. A group without a barrier can still be placed on a cluster whose barrier slots are all used, while a group that needs a barrier skips that cluster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Head slot empty, request accepted this edge |
| req_threads | input | 8 | Thread slots the group needs |
| req_barrier | input | 1 | Group needs a barrier slot |
| req_shmem | input | 18 | Shared-memory bytes the group needs |
| grant_valid | output | 1 | Placement result present |
| grant_ready | input | 1 | Consumer takes the result |
| grant_cluster | output | 2 | Chosen cluster index |
| grant_error | output | 1 | Group exceeds an empty cluster's capacity |
| done_valid | input | 1 | Completion message present |
| done_cluster | input | 2 | Cluster whose group finished |
| done_threads | input | 8 | Thread slots released |
| done_barrier | input | 1 | A barrier slot is released |
| done_shmem | input | 18 | Shared-memory bytes released |

## Verification
An accepted request reaches the head slot at the accepting edge and is decided at the next edge. The bench drives on falling edges. It checks that grant_valid is still low half a cycle after acceptance and high one full cycle later. A stalled group is released by a completion that is sampled at one edge and becomes a grant at the next, so the bench checks both of those falling-edge samples as well. Under backpressure the bench samples the grant on several successive falling edges. For each of these timing points it compares the result against a free-count model that it keeps for itself.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
    localparam int DEF_SLICES       = 2;
    localparam int DEF_CL_PER_SLICE = 2;
    localparam int DEF_EU_PER_CL    = 10;
    localparam int DEF_THR_PER_EU   = 7;
    localparam int DEF_BAR_PER_CL   = 16;
    localparam int DEF_SHM_PER_CL   = 65536;
    localparam int DEF_THR_IN_W     = 8;
    localparam int DEF_SHM_IN_W     = 18;
endpackage

// File: rtl/wgd_pick.sv
module wgd_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  fit,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fit[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wgd_ledger.sv
module wgd_ledger #(
    parameter int THR_CAP  = 70,
    parameter int BAR_CAP  = 16,
    parameter int SHM_CAP  = 65536,
    parameter int THR_IN_W = 8,
    parameter int SHM_IN_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [THR_IN_W-1:0] need_thr,
    input  logic                need_bar,
    input  logic [SHM_IN_W-1:0] need_shm,
    input  logic                take,
    input  logic                give,
    input  logic [THR_IN_W-1:0] give_thr,
    input  logic                give_bar,
    input  logic [SHM_IN_W-1:0] give_shm,
    output logic                fits
);
    localparam int THR_W = $clog2(THR_CAP + 1);
    localparam int BAR_W = $clog2(BAR_CAP + 1);
    localparam int SHM_W = $clog2(SHM_CAP + 1);

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [BAR_W-1:0] bar;
        logic [SHM_W-1:0] shm;
    } pool_t;

    pool_t       pool_d, pool_q;
    logic [31:0] thr_sum, bar_sum, shm_sum;

    always_comb begin
        fits = (32'(need_thr) <= 32'(pool_q.thr)) &&
               (!need_bar || pool_q.bar != '0) &&
               (32'(need_shm) <= 32'(pool_q.shm));
        thr_sum = 32'(pool_q.thr) - (take ? 32'(need_thr) : 32'd0)
                                  + (give ? 32'(give_thr) : 32'd0);
        bar_sum = 32'(pool_q.bar) - ((take && need_bar) ? 32'd1 : 32'd0)
                                  + ((give && give_bar) ? 32'd1 : 32'd0);
        shm_sum = 32'(pool_q.shm) - (take ? 32'(need_shm) : 32'd0)
                                  + (give ? 32'(give_shm) : 32'd0);
        pool_d.thr = thr_sum[THR_W-1:0];
        pool_d.bar = bar_sum[BAR_W-1:0];
        pool_d.shm = shm_sum[SHM_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pool_q.thr <= THR_W'(THR_CAP);
            pool_q.bar <= BAR_W'(BAR_CAP);
            pool_q.shm <= SHM_W'(SHM_CAP);
        end else begin
            pool_q <= pool_d;
        end
    end

    assert_thr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pool_q.thr) <= 32'(THR_CAP));
    assert_bar_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pool_q.bar) <= 32'(BAR_CAP));
    assert_shm_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pool_q.shm) <= 32'(SHM_CAP));
    assert_take_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> fits);
endmodule

// File: rtl/wg_dispatch.sv
module wg_dispatch #(
    parameter int SLICES       = wgd_pkg::DEF_SLICES,
    parameter int CL_PER_SLICE = wgd_pkg::DEF_CL_PER_SLICE,
    parameter int EU_PER_CL    = wgd_pkg::DEF_EU_PER_CL,
    parameter int THR_PER_EU   = wgd_pkg::DEF_THR_PER_EU,
    parameter int BAR_PER_CL   = wgd_pkg::DEF_BAR_PER_CL,
    parameter int SHM_PER_CL   = wgd_pkg::DEF_SHM_PER_CL,
    parameter int THR_IN_W     = wgd_pkg::DEF_THR_IN_W,
    parameter int SHM_IN_W     = wgd_pkg::DEF_SHM_IN_W,
    localparam int NUM_CL      = SLICES * CL_PER_SLICE,
    localparam int CIW         = (NUM_CL > 1) ? $clog2(NUM_CL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [THR_IN_W-1:0] req_threads,
    input  logic                req_barrier,
    input  logic [SHM_IN_W-1:0] req_shmem,
    output logic                grant_valid,
    input  logic                grant_ready,
    output logic [CIW-1:0]      grant_cluster,
    output logic                grant_error,
    input  logic                done_valid,
    input  logic [CIW-1:0]      done_cluster,
    input  logic [THR_IN_W-1:0] done_threads,
    input  logic                done_barrier,
    input  logic [SHM_IN_W-1:0] done_shmem
);
    localparam int THR_CAP = EU_PER_CL * THR_PER_EU;

    typedef struct packed {
        logic                head_v;
        logic [THR_IN_W-1:0] head_thr;
        logic                head_bar;
        logic [SHM_IN_W-1:0] head_shm;
        logic                out_v;
        logic [CIW-1:0]      out_cl;
        logic                out_err;
    } st_t;

    st_t             st_d, st_q;
    logic [NUM_CL-1:0] fit_vec, take_vec;
    logic            any_fit, oversize, slot_free, fire;
    logic [CIW-1:0]  pick_idx;

    for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
        wgd_ledger #(
            .THR_CAP (THR_CAP),
            .BAR_CAP (BAR_PER_CL),
            .SHM_CAP (SHM_PER_CL),
            .THR_IN_W(THR_IN_W),
            .SHM_IN_W(SHM_IN_W)
        ) u_ledger (
            .clk     (clk),
            .rst_n   (rst_n),
            .need_thr(st_q.head_thr),
            .need_bar(st_q.head_bar),
            .need_shm(st_q.head_shm),
            .take    (take_vec[c]),
            .give    (done_valid && (32'(done_cluster) == c)),
            .give_thr(done_threads),
            .give_bar(done_barrier),
            .give_shm(done_shmem),
            .fits    (fit_vec[c])
        );
    end

    wgd_pick #(.N(NUM_CL), .IW(CIW)) u_pick (
        .fit  (fit_vec),
        .found(any_fit),
        .idx  (pick_idx)
    );

    always_comb begin
        st_d      = st_q;
        oversize  = (32'(st_q.head_thr) > 32'(THR_CAP)) ||
                    (32'(st_q.head_shm) > 32'(SHM_PER_CL));
        slot_free = !st_q.out_v || grant_ready;
        fire      = st_q.head_v && slot_free && (oversize || any_fit);
        take_vec  = '0;
        if (st_q.out_v && grant_ready) st_d.out_v = 1'b0;
        if (fire) begin
            st_d.out_v   = 1'b1;
            st_d.out_err = oversize;
            st_d.out_cl  = oversize ? '0 : pick_idx;
            st_d.head_v  = 1'b0;
            if (!oversize) take_vec[pick_idx] = 1'b1;
        end
        if (req_valid && !st_q.head_v) begin
            st_d.head_v   = 1'b1;
            st_d.head_thr = req_threads;
            st_d.head_bar = req_barrier;
            st_d.head_shm = req_shmem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready     = !st_q.head_v;
    assign grant_valid   = st_q.out_v;
    assign grant_cluster = st_q.out_cl;
    assign grant_error   = st_q.out_err;

    assert_single_cluster_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec));
    assert_hold_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_cluster)
                                           && $stable(grant_error)));
    assert_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_err_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_error) |-> (grant_cluster == '0));
endmodule

// File: tb/tb_wg_dispatch.sv
module tb_wg_dispatch;
    localparam int NC = 4, TCAP = 70, BCAP = 16, SCAP = 65536;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_barrier = 0, grant_ready = 1;
    logic [7:0] req_threads = 0, done_threads = 0;
    logic [17:0] req_shmem = 0, done_shmem = 0;
    logic done_valid = 0, done_barrier = 0;
    logic [1:0] done_cluster = 0;
    logic req_ready, grant_valid, grant_error;
    logic [1:0] grant_cluster;

    int total = 0, bad = 0;
    int ft[NC], fb[NC], fs[NC];
    int oc[256], ot[256], ob[256], os[256];
    int oh = 0, otl = 0;

    always #2.5 clk = ~clk;

    wg_dispatch dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_threads(req_threads),
        .req_barrier(req_barrier), .req_shmem(req_shmem),
        .grant_valid(grant_valid), .grant_ready(grant_ready),
        .grant_cluster(grant_cluster), .grant_error(grant_error),
        .done_valid(done_valid), .done_cluster(done_cluster),
        .done_threads(done_threads), .done_barrier(done_barrier), .done_shmem(done_shmem)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int pick(int t, int b, int s);
        for (int c = 0; c < NC; c++)
            if (t <= ft[c] && (b == 0 || fb[c] > 0) && s <= fs[c]) return c;
        return -1;
    endfunction

    task automatic release_oldest();
        int k = oh % 256;
        @(negedge clk);
        done_valid = 1; done_cluster = 2'(oc[k]); done_threads = 8'(ot[k]);
        done_barrier = ob[k][0]; done_shmem = 18'(os[k]);
        @(negedge clk);
        done_valid = 0;
        ft[oc[k]] += ot[k]; fb[oc[k]] += ob[k]; fs[oc[k]] += os[k];
        oh++;
    endtask

    task automatic push(int t, int b, int s);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_threads = 8'(t); req_barrier = b[0]; req_shmem = 18'(s);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic run_req(int t, int b, int s, string tag);
        bit over = (t > TCAP) || (s > SCAP);
        int e = 0;
        if (!over) begin
            while (pick(t, b, s) < 0) release_oldest();
            e = pick(t, b, s);
        end
        push(t, b, s);
        chk("R2", "grant_valid half cycle after accept", int'(grant_valid), 0);
        @(negedge clk);
        chk(tag, "grant_valid", int'(grant_valid), 1);
        chk(tag, "grant_error", int'(grant_error), int'(over));
        chk(tag, "grant_cluster", int'(grant_cluster), e);
        if (!over) begin
            ft[e] -= t; fb[e] -= b; fs[e] -= s;
            oc[otl % 256] = e; ot[otl % 256] = t; ob[otl % 256] = b; os[otl % 256] = s;
            otl++;
        end
    endtask

    task automatic drain();
        while (oh != otl) release_oldest();
    endtask

    initial begin
        #(5.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin ft[c] = TCAP; fb[c] = BCAP; fs[c] = SCAP; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "grant_valid after reset", int'(grant_valid), 0);
        chk("R1", "req_ready after reset", int'(req_ready), 1);

        // R1 then R9: barrier slots on cluster 0 run out after 16 groups
        run_req(1, 1, 0, "R1");
        for (int i = 1; i < BCAP; i++) run_req(1, 1, 0, "R9");
        run_req(1, 1, 0, "R9");
        run_req(1, 0, 0, "R9");
        drain();

        // R5: oversize, nothing deducted
        run_req(71, 0, 0, "R5");
        run_req(10, 0, 65537, "R5");
        run_req(70, 0, SCAP, "R3");
        run_req(1, 0, 0, "R3");
        drain();

        // R4, R6, R7: fill all clusters, then stall
        for (int c = 0; c < NC; c++) run_req(TCAP, 0, 0, "R3");
        push(1, 0, 0);
        req_valid = 1; req_threads = 8'd2;
        for (int i = 0; i < 4; i++) begin
            chk("R4", "stalled grant_valid", int'(grant_valid), 0);
            chk("R7", "req_ready while head waits", int'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 0;
        done_valid = 1; done_cluster = 2'd2; done_threads = 8'd70;
        done_barrier = 0; done_shmem = 0;
        @(negedge clk);
        done_valid = 0;
        chk("R6", "grant_valid right after release edge", int'(grant_valid), 0);
        @(negedge clk);
        chk("R6", "grant_valid after release", int'(grant_valid), 1);
        chk("R6", "grant_cluster after release", int'(grant_cluster), 2);
        chk("R4", "grant_error after release", int'(grant_error), 0);
        chk("R7", "req_ready once head placed", int'(req_ready), 1);
        ft[2] = TCAP - 1;
        oc[(otl - 2) % 256] = 2; ot[(otl - 2) % 256] = 1;
        drain();

        // R8: backpressure hold and handoff to the next group
        grant_ready = 0;
        push(5, 0, 100);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R8", "held grant_valid", int'(grant_valid), 1);
            chk("R8", "held grant_cluster", int'(grant_cluster), 0);
            @(negedge clk);
        end
        push(TCAP, 0, 0);
        @(negedge clk);
        chk("R8", "held grant_cluster with second queued", int'(grant_cluster), 0);
        grant_ready = 1;
        @(negedge clk);
        chk("R8", "second grant_valid", int'(grant_valid), 1);
        chk("R8", "second grant_cluster", int'(grant_cluster), 1);
        ft[0] -= 5; fs[0] -= 100; ft[1] -= TCAP;
        oc[otl % 256] = 0; ot[otl % 256] = 5; ob[otl % 256] = 0; os[otl % 256] = 100; otl++;
        oc[otl % 256] = 1; ot[otl % 256] = TCAP; ob[otl % 256] = 0; os[otl % 256] = 0; otl++;
        @(negedge clk);
        drain();

        // R2/R3/R4/R6 sweep against the model
        for (int i = 0; i < 240; i++) begin
            int t = (i * 37 + 5) % 75;
            int s = ((i * 7919) % 9) * 8192;
            int b = ((i % 3) == 0) ? 1 : 0;
            if ((i % 23) == 0) s = SCAP + 64;
            run_req(t, b, s, "R2");
            if ((i % 5) == 4 && oh != otl) release_oldest();
        end
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule